// File: doc/BRIEF.md
# Consecutive-Period Fault Qualifier

This block qualifies fault indications for one PWM channel before they are allowed to shut the channel down. It holds four identically built qualification units: one for cycle-by-cycle events, one that kills both drive outputs, one that kills only output A and one that kills only output B. Each unit looks at its own fault input and notes at most one fault per switching period. A period-start pulse marks the boundary between periods.

At each period boundary a unit adds one to its run count if the period that just ended contained a fault. If the period was clean, the run count returns to zero. When the run count goes above that unit's programmed limit, the unit's flag latches. A latched flag forces the matching PWM drive outputs low until the channel's PWM enable is dropped. Dropping the enable clears all four units in the same cycle. A single global fault enable arms or disarms all four units together. Selecting which fault sources feed each input is done elsewhere.

Top module: `pwm_fault_qual`

## Requirements
- R1: After reset all four flags are 0, and pwm_a_o and pwm_b_o equal pwm_a_i and pwm_b_i.
- R2: A unit counts a switching period at most once, however many cycles its fault input is high within that period.
- R3: The period that ends is evaluated in the cycle where period_start_i is high. A fault seen in that same cycle belongs to the new period. A unit's flag sets at that edge when its consecutive faulted-period count becomes greater than its own limit, which is max_cnt_i[i*CW +: CW] for unit i. The flag is visible on flag_o in the following cycle.
- R4: A period that closes with no fault seen returns that unit's count to zero, so only unbroken runs of faulted periods can set a flag.
- R5: While fault_en_i is low, all counts are held at zero and fault inputs have no effect. Counting restarts from zero when fault_en_i returns high.
- R6: A set flag stays set through clean periods and while fault_en_i is low, as long as pwm_en_i stays high.
- R7: pwm_en_i low clears all four flags and all counts in the same clock.
- R8: The count saturates at 2^CW-1 and does not wrap. With a limit of all ones a flag never sets. If the limit is later lowered, the saturated count is compared against the new limit.
- R9: The flag index mapping is fixed as 0 = cycle-by-cycle, 1 = both outputs, 2 = output A, 3 = output B. Flags 0 and 1 force both outputs low, flag 2 forces only pwm_a_o low, and flag 3 forces only pwm_b_o low. This gating acts in the cycle after the flag's setting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwm_en_i | input | 1 | PWM enable; low clears all flags and counts |
| fault_en_i | input | 1 | Global arm for all four units |
| period_start_i | input | 1 | One-cycle pulse at the start of each switching period |
| fault_i | input | 4 | Fault inputs, index 0 cbc, 1 both, 2 A, 3 B |
| max_cnt_i | input | 4*CW | Per-unit limits, unit i at bits [i*CW +: CW] |
| pwm_a_i | input | 1 | Ungated PWM output A |
| pwm_b_i | input | 1 | Ungated PWM output B |
| flag_o | output | 4 | Latched fault flags |
| pwm_a_o | output | 1 | Gated PWM output A |
| pwm_b_o | output | 1 | Gated PWM output B |

## Verification
Every count lives inside a unit and shows at the ports only through the flag. A count that is off by one, that wraps, or that was not cleared therefore appears as a flag that sets one boundary early or late. The bench closes each run with a boundary and samples the flag in the cycle that follows. Saturation has no visible effect on its own, so the bench lowers the limit after a long run; a wrapped count shows there as a missing flag. A flag that clears when it should hold, or holds when it should clear, shows on the gated outputs within one cycle.

// File: rtl/fault_qual_pkg.sv
package fault_qual_pkg;
  localparam int unsigned N_UNIT  = 4;
  localparam int unsigned IDX_CBC = 0;
  localparam int unsigned IDX_AB  = 1;
  localparam int unsigned IDX_A   = 2;
  localparam int unsigned IDX_B   = 3;
endpackage

// File: rtl/fault_period_detect.sv
module fault_period_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic period_start_i,
  input  logic fault_i,
  output logic seen_o
);
  logic seen_q;

  // fault in the start cycle belongs to the new period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             seen_q <= 1'b0;
    else if (clr_i)          seen_q <= 1'b0;
    else if (period_start_i) seen_q <= fault_i;
    else if (fault_i)        seen_q <= 1'b1;
  end

  assign seen_o = seen_q;

  a_r2_seen_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !period_start_i && !clr_i) |=> seen_q);
endmodule

// File: rtl/fault_run_counter.sv
module fault_run_counter #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwm_en_i,
  input  logic          fault_en_i,
  input  logic          period_start_i,
  input  logic          seen_i,
  input  logic [CW-1:0] max_i,
  output logic          flag_o
);
  localparam logic [CW-1:0] CNT_TOP = '1;

  logic [CW-1:0] cnt_q, cnt_inc;
  logic          flag_q;

  assign cnt_inc = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (!pwm_en_i) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (!fault_en_i) begin
      cnt_q  <= '0;
    end else if (period_start_i) begin
      if (seen_i) begin
        cnt_q <= cnt_inc;
        if (cnt_inc > max_i) flag_q <= 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign flag_o = flag_q;

  a_r2_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_en_i && fault_en_i && !period_start_i) |=> $stable(cnt_q));
  a_r3_set_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(period_start_i));
  a_r5_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_en_i && !fault_en_i) |=> (cnt_q == '0));
  a_r6_flag_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_en_i && flag_q) |=> flag_q);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_en_i |=> (!flag_q && cnt_q == '0));
  a_r8_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_en_i && fault_en_i && period_start_i && seen_i && cnt_q == CNT_TOP)
    |=> (cnt_q == CNT_TOP));
endmodule

// File: rtl/fault_qual_unit.sv
module fault_qual_unit #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwm_en_i,
  input  logic          fault_en_i,
  input  logic          period_start_i,
  input  logic          fault_i,
  input  logic [CW-1:0] max_i,
  output logic          flag_o
);
  logic seen;
  logic clr;

  assign clr = !pwm_en_i || !fault_en_i;

  fault_period_detect u_detect (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clr_i          (clr),
    .period_start_i (period_start_i),
    .fault_i        (fault_i),
    .seen_o         (seen)
  );

  fault_run_counter #(.CW(CW)) u_count (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pwm_en_i       (pwm_en_i),
    .fault_en_i     (fault_en_i),
    .period_start_i (period_start_i),
    .seen_i         (seen),
    .max_i          (max_i),
    .flag_o         (flag_o)
  );
endmodule

// File: rtl/fault_out_gate.sv
module fault_out_gate
  import fault_qual_pkg::*;
(
  input  logic [N_UNIT-1:0] flag_i,
  input  logic              pwm_a_i,
  input  logic              pwm_b_i,
  output logic              pwm_a_o,
  output logic              pwm_b_o
);
  logic kill_a, kill_b;

  assign kill_a  = flag_i[IDX_CBC] | flag_i[IDX_AB] | flag_i[IDX_A];
  assign kill_b  = flag_i[IDX_CBC] | flag_i[IDX_AB] | flag_i[IDX_B];
  assign pwm_a_o = pwm_a_i & ~kill_a;
  assign pwm_b_o = pwm_b_i & ~kill_b;
endmodule

// File: rtl/pwm_fault_qual.sv
module pwm_fault_qual
  import fault_qual_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pwm_en_i,
  input  logic                 fault_en_i,
  input  logic                 period_start_i,
  input  logic [N_UNIT-1:0]    fault_i,
  input  logic [N_UNIT*CW-1:0] max_cnt_i,
  input  logic                 pwm_a_i,
  input  logic                 pwm_b_i,
  output logic [N_UNIT-1:0]    flag_o,
  output logic                 pwm_a_o,
  output logic                 pwm_b_o
);
  logic [N_UNIT-1:0] flag;

  for (genvar gi = 0; gi < N_UNIT; gi++) begin : g_unit
    fault_qual_unit #(.CW(CW)) u_unit (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .pwm_en_i       (pwm_en_i),
      .fault_en_i     (fault_en_i),
      .period_start_i (period_start_i),
      .fault_i        (fault_i[gi]),
      .max_i          (max_cnt_i[gi*CW +: CW]),
      .flag_o         (flag[gi])
    );
  end

  fault_out_gate u_gate (
    .flag_i  (flag),
    .pwm_a_i (pwm_a_i),
    .pwm_b_i (pwm_b_i),
    .pwm_a_o (pwm_a_o),
    .pwm_b_o (pwm_b_o)
  );

  assign flag_o = flag;

  a_r9_gate_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag[IDX_A] || flag[IDX_AB] || flag[IDX_CBC]) |-> !pwm_a_o);
  a_r9_gate_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag[IDX_B] || flag[IDX_AB] || flag[IDX_CBC]) |-> !pwm_b_o);
  a_r7_all_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_en_i |=> (flag == '0));
endmodule

// File: tb/pwm_fault_qual_bench.sv
module pwm_fault_qual_bench;
  localparam int CW = 4;
  localparam int PLEN = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwm_en = 1'b0;
  logic          fault_en = 1'b0;
  logic          pstart = 1'b0;
  logic [3:0]    fault = '0;
  logic [4*CW-1:0] max_cnt = '1;
  logic          pa_i = 1'b1, pb_i = 1'b1;
  logic [3:0]    flag;
  logic          pa_o, pb_o;
  int            total = 0;
  int            bad = 0;

  always #2 clk = ~clk;

  pwm_fault_qual #(.CW(CW)) u_pwm_fault_qual (
    .clk_i(clk), .rst_ni(rst_n), .pwm_en_i(pwm_en), .fault_en_i(fault_en),
    .period_start_i(pstart), .fault_i(fault), .max_cnt_i(max_cnt),
    .pwm_a_i(pa_i), .pwm_b_i(pb_i), .flag_o(flag), .pwm_a_o(pa_o), .pwm_b_o(pb_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_max(input int idx, input int v);
    max_cnt[idx*CW +: CW] = v[CW-1:0];
  endtask

  // one period of PLEN cycles; npulse separate fault pulses on mask
  task automatic drive_period(input logic [3:0] mask, input int npulse);
    for (int c = 0; c < PLEN; c++) begin
      @(negedge clk);
      pstart = (c == 0);
      fault  = (c % 2 == 1 && c < 2*npulse) ? mask : 4'b0;
    end
  endtask

  // closes the running period; flag visible at return
  task automatic close_period();
    @(negedge clk); pstart = 1'b1; fault = '0;
    @(negedge clk); pstart = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk); pwm_en = 1'b0;
    @(negedge clk); pwm_en = 1'b1;
  endtask

  task automatic t_reset();
    check("R1", "flags after reset", int'(flag), 0);
    pa_i = 1'b0; pb_i = 1'b1; #1;
    check("R1", "pass a=0", int'(pa_o), 0);
    check("R1", "pass b=1", int'(pb_o), 1);
    pa_i = 1'b1; pb_i = 1'b0; #1;
    check("R1", "pass a=1", int'(pa_o), 1);
    check("R1", "pass b=0", int'(pb_o), 0);
    pb_i = 1'b1;
  endtask

  task automatic t_threshold();
    set_max(2, 2);
    repeat (2) drive_period(4'b0100, 1);
    close_period();
    check("R3", "A flag at count==max", int'(flag[2]), 0);
    repeat (3) drive_period(4'b0100, 1);
    close_period();
    check("R3", "A flag at count>max", int'(flag[2]), 1);
    check("R9", "A gates a", int'(pa_o), 0);
    check("R9", "A leaves b", int'(pb_o), 1);
    check("R3", "other flags", int'(flag & 4'b1011), 0);
    repeat (2) drive_period(4'b0000, 0);
    check("R6", "A flag holds over clean periods", int'(flag[2]), 1);
    clear_all();
    check("R7", "flags cleared", int'(flag), 0);
    check("R7", "a restored", int'(pa_o), 1);
  endtask

  task automatic t_once_per_period();
    set_max(2, 2);
    repeat (2) drive_period(4'b0100, 6);
    close_period();
    check("R2", "many pulses count once", int'(flag[2]), 0);
    drive_period(4'b0100, 6);
    close_period();
    check("R2", "many pulses single period", int'(flag[2]), 0);
  endtask

  task automatic t_start_cycle();
    set_max(3, 0);
    // fault only in the closing start cycle opens the next period
    @(negedge clk); pstart = 1'b1; fault = 4'b1000;
    @(negedge clk); pstart = 1'b0; fault = '0;
    check("R3", "start-cycle fault not in closed period", int'(flag[3]), 0);
    close_period();
    check("R3", "start-cycle fault in new period", int'(flag[3]), 1);
    clear_all();
  endtask

  task automatic t_consecutive();
    set_max(3, 1);
    drive_period(4'b1000, 1);
    drive_period(4'b0000, 0);
    drive_period(4'b1000, 1);
    close_period();
    check("R4", "broken run no flag", int'(flag[3]), 0);
    drive_period(4'b1000, 1);
    drive_period(4'b1000, 1);
    close_period();
    check("R4", "unbroken run flag", int'(flag[3]), 1);
    check("R9", "B gates b", int'(pb_o), 0);
    check("R9", "B leaves a", int'(pa_o), 1);
    clear_all();
  endtask

  task automatic t_fault_enable();
    set_max(3, 0);
    @(negedge clk); fault_en = 1'b0;
    repeat (3) drive_period(4'b1000, 2);
    close_period();
    check("R5", "disabled ignores faults", int'(flag[3]), 0);
    @(negedge clk); fault_en = 1'b1;
    drive_period(4'b1000, 1);
    close_period();
    check("R5", "re-armed counts from zero", int'(flag[3]), 1);
    @(negedge clk); fault_en = 1'b0;
    repeat (5) @(negedge clk);
    check("R6", "flag held with fault_en low", int'(flag[3]), 1);
    check("R6", "b still gated", int'(pb_o), 0);
    @(negedge clk); fault_en = 1'b1;
    clear_all();
  endtask

  task automatic t_saturate();
    set_max(2, 15);
    repeat (20) drive_period(4'b0100, 1);
    check("R8", "all-ones limit never sets", int'(flag[2]), 0);
    set_max(2, 14);
    drive_period(4'b0100, 1);
    close_period();
    check("R8", "saturated count vs lowered limit", int'(flag[2]), 1);
    clear_all();
  endtask

  task automatic t_both_outputs();
    for (int i = 0; i < 4; i++) set_max(i, 0);
    drive_period(4'b0010, 1);
    close_period();
    check("R9", "AB flag", int'(flag), 2);
    check("R9", "AB gates a", int'(pa_o), 0);
    check("R9", "AB gates b", int'(pb_o), 0);
    clear_all();
    drive_period(4'b0001, 1);
    close_period();
    check("R9", "CBC flag", int'(flag), 1);
    check("R9", "CBC gates a", int'(pa_o), 0);
    check("R9", "CBC gates b", int'(pb_o), 0);
    clear_all();
    drive_period(4'b1100, 1);
    close_period();
    check("R7", "A and B set", int'(flag), 12);
    @(negedge clk); pwm_en = 1'b0;
    @(negedge clk);
    check("R7", "cleared together", int'(flag), 0);
    pwm_en = 1'b1;
    drive_period(4'b0000, 0);
    close_period();
    check("R7", "stay clear after enable", int'(flag), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; pwm_en = 1'b1; fault_en = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_once_per_period();
    clear_all();
    t_start_cycle();
    t_consecutive();
    t_fault_enable();
    t_saturate();
    t_both_outputs();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule